// File: doc/BRIEF.md
# Double-Buffered BCD Real-Time Clock Registers

This block keeps calendar time in packed BCD. A one-cycle `tick_1hz` pulse advances a set of internal counters: seconds, minutes, 24-hour hours, day of week, date, month, two-digit year and a century. These counters run at all times. Software never sees them directly. It reads and writes a second, user-visible copy over a simple parallel bus with active-low chip enable, output enable and write enable. The bus is sampled on each rising clock edge, so a write takes effect at the next edge. A read is combinational while it is selected. Every access completes in the cycle it is presented. There is no valid/ready pairing and no back-pressure, because the register file can always accept or supply a byte.

A control byte at address 0 holds two halt bits and the century. The read-halt bit freezes the visible copy, so software can take a coherent snapshot. The write-halt bit also freezes the copy, so software can load a new time. Clearing the write-halt bit transfers the visible copy into the internal counters. Refreshes of the visible copy from the counters resume only after both halt bits have stayed clear for `MIN_LOW_CYC` clock cycles, and `MIN_LOW_CYC` must be at least 1.

Two digital supply-status inputs gate the bus. While the supply is out of tolerance, or below the backup level, every access is ignored and the data output stays disabled.

Top module: `rtc_dbuf_top`

## Requirements
- R1: The internal counters advance by one second on every `tick_1hz` pulse whatever the halt bits and bus activity are, so time elapsed during a halt shows after the halt is released.
- R2: Time is 24-hour packed BCD. Seconds and minutes wrap 59 to 00, hours wrap 23 to 00, and day of week counts 1..7 and wraps 7 to 1 when the hour wraps.
- R3: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 28 for month 02 (29 when the year is divisible by 4), otherwise 31. Month wraps 12 to 01, year wraps 99 to 00, and that wrap increments the century (39 wraps to 00).
- R4: Address map: 0 is the control byte, with bit 7 write-halt, bit 6 read-halt and bits 5:0 the century in BCD. Addresses 1 to 7 are seconds, minutes, hours, day, date, month and year. Reading address 0 returns the current halt bits with the visible century.
- R5: While read-halt is 1, the visible copy keeps the values it held when the bit was set (bus writes excepted).
- R6: After both halt bits are 0, no refresh happens until they have stayed 0 for `MIN_LOW_CYC` cycles. At that point a refresh pending from a halt release happens at once. From then on the visible copy is refreshed from the counters in the cycle after each tick.
- R7: While write-halt is 1, writes land in the visible copy and are not overwritten. Writing the control byte with bit 7 = 0 while write-halt is 1 loads the visible values, with the century just written, into the counters.
- R8: A write to a time register while both halt bits are 0 changes only the visible copy, and the next refresh replaces it.
- R9: Bus decode: with `ce_n`=1 nothing happens. With `ce_n`=0 and `we_n`=0 the access is a write. With `ce_n`=0, `oe_n`=0 and `we_n`=1 the access is a read and `dout_en`=1. With `ce_n`=0 and `oe_n`=`we_n`=1, `dout_en`=0.
- R10: When `vcc_in_tol`=0 or `vcc_below_bat`=1, writes are ignored and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; counters and copy start at 20/00-01-01, day 1, 00:00:00 |
| tick_1hz | input | 1 | One-cycle pulse per second |
| vcc_in_tol | input | 1 | 1 when the main supply is within tolerance |
| vcc_below_bat | input | 1 | 1 when the main supply has fallen under the backup level |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 3 | Register address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not reading |
| dout_en | output | 1 | Read data is driven |

## Verification
The bench builds the block with `MIN_LOW_CYC` = 8 in place of the production value, which corresponds to several hundred microseconds of clock cycles. With this value, a halt release, the full guard interval and the refresh that follows fit into a few dozen cycles. The bench can therefore check the copy both inside the guard interval and just after it. It also loads times just before each kind of rollover, so every carry path, including leap February and the century carry, is reached with a single tick.

// File: rtl/rtc_dbuf_pkg.sv
package rtc_dbuf_pkg;

  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam int unsigned NUM_REGS = 8;
  localparam logic [2:0]  A_CTRL   = 3'd0;

  localparam rtc_time_t RTC_RESET_TIME = '{
    cen: 8'h20, yr: 8'h00, mon: 8'h01, date: 8'h01,
    day: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00
  };

  // packed BCD successor without range limit
  function automatic logic [7:0] bcd_succ(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // year (two BCD digits) divisible by four
  function automatic logic leap_yr(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_yr(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // register file byte at a bus address
  function automatic logic [7:0] field_at(input rtc_time_t t, input logic [2:0] a);
    case (a)
      3'd0:    return t.cen;
      3'd1:    return t.sec;
      3'd2:    return t.min;
      3'd3:    return t.hr;
      3'd4:    return t.day;
      3'd5:    return t.date;
      3'd6:    return t.mon;
      default: return t.yr;
    endcase
  endfunction

endpackage

// File: rtl/rtc_dbuf_bus.sv
module rtc_dbuf_bus (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic vcc_in_tol,
  input  logic vcc_below_bat,
  output logic wr_en,
  output logic rd_en
);

  logic supply_good;

  assign supply_good = vcc_in_tol && !vcc_below_bat;
  assign wr_en       = supply_good && !ce_n && !we_n;
  assign rd_en       = supply_good && !ce_n && !oe_n && we_n;

  assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

  assert_no_read_low_supply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!vcc_in_tol || vcc_below_bat) |-> !rd_en && !wr_en);

  assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !rd_en && !wr_en);

endmodule

// File: rtl/rtc_dbuf_counters.sv
module rtc_dbuf_counters
  import rtc_dbuf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cur
);

  rtc_time_t nxt;
  logic w_sec, w_min, w_hr, w_date, w_mon, w_yr;

  always_comb begin
    nxt    = cur;
    w_sec  = (cur.sec == 8'h59);
    w_min  = 1'b0;
    w_hr   = 1'b0;
    w_date = 1'b0;
    w_mon  = 1'b0;
    w_yr   = 1'b0;
    nxt.sec = w_sec ? 8'h00 : bcd_succ(cur.sec);
    if (w_sec) begin
      w_min   = (cur.min == 8'h59);
      nxt.min = w_min ? 8'h00 : bcd_succ(cur.min);
    end
    if (w_min) begin
      w_hr   = (cur.hr == 8'h23);
      nxt.hr = w_hr ? 8'h00 : bcd_succ(cur.hr);
    end
    if (w_hr) begin
      nxt.day  = (cur.day == 8'h07) ? 8'h01 : bcd_succ(cur.day);
      w_date   = (cur.date == month_last(cur.mon, cur.yr));
      nxt.date = w_date ? 8'h01 : bcd_succ(cur.date);
    end
    if (w_date) begin
      w_mon   = (cur.mon == 8'h12);
      nxt.mon = w_mon ? 8'h01 : bcd_succ(cur.mon);
    end
    if (w_mon) begin
      w_yr   = (cur.yr == 8'h99);
      nxt.yr = w_yr ? 8'h00 : bcd_succ(cur.yr);
    end
    if (w_yr) begin
      nxt.cen = (cur.cen == 8'h39) ? 8'h00 : bcd_succ(cur.cen);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= RTC_RESET_TIME;
    else if (load) cur <= load_val;
    else if (tick) cur <= nxt;
  end

  assert_tick_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> cur.sec != $past(cur.sec));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cur));

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur.sec == 8'h59) |=> cur.sec == 8'h00);

  assert_hour_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur.sec == 8'h59 && cur.min == 8'h59 && cur.hr == 8'h23)
      |=> cur.hr == 8'h00);

  assert_load_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur == $past(load_val));

endmodule

// File: rtl/rtc_dbuf_shadow.sv
module rtc_dbuf_shadow
  import rtc_dbuf_pkg::*;
#(
  parameter int unsigned MIN_LOW_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  rtc_time_t  cur,
  output rtc_time_t  vis,
  output logic       rhalt,
  output logic       whalt,
  output logic       load,
  output rtc_time_t  load_val
);

  localparam int unsigned CNT_W = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CNT_W-1:0] LOW_MAX = CNT_W'(MIN_LOW_CYC);

  logic [7:0]       vis_r [NUM_REGS];
  logic [CNT_W-1:0] low_cnt;
  logic             rh_q, wh_q, pend_q, tick_q;
  logic             ctrl_wr, rh_n, wh_n, armed, refresh, release_ev;

  assign ctrl_wr    = wr_en && (addr == A_CTRL);
  assign rh_n       = ctrl_wr ? wdata[6] : rh_q;
  assign wh_n       = ctrl_wr ? wdata[7] : wh_q;
  assign release_ev = (rh_q && !rh_n) || (wh_q && !wh_n);
  assign armed      = !rh_q && !wh_q && (low_cnt == LOW_MAX);
  assign refresh    = armed && (tick_q || pend_q);

  assign load = ctrl_wr && wh_q && !wdata[7];

  always_comb begin
    load_val     = vis;
    load_val.cen = {2'b00, wdata[5:0]};
  end

  assign vis = '{cen: vis_r[0], sec: vis_r[1], min: vis_r[2], hr: vis_r[3],
                 day: vis_r[4], date: vis_r[5], mon: vis_r[6], yr: vis_r[7]};
  assign rhalt = rh_q;
  assign whalt = wh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rh_q    <= 1'b0;
      wh_q    <= 1'b0;
      pend_q  <= 1'b1;
      tick_q  <= 1'b0;
      low_cnt <= '0;
    end else begin
      rh_q   <= rh_n;
      wh_q   <= wh_n;
      tick_q <= tick;
      if (release_ev)   pend_q <= 1'b1;
      else if (refresh) pend_q <= 1'b0;
      if (rh_q || wh_q)            low_cnt <= '0;
      else if (low_cnt != LOW_MAX) low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_REGS; k++) vis_r[k] <= field_at(RTC_RESET_TIME, 3'(k));
    end else begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (wr_en && addr == 3'(k))
          vis_r[k] <= (k == 0) ? {2'b00, wdata[5:0]} : wdata;
        else if (refresh)
          vis_r[k] <= field_at(cur, 3'(k));
      end
    end
  end

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rh_q && !wr_en) |=> $stable(vis));

  assert_write_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wh_q && !wr_en) |=> $stable(vis));

  assert_guard_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rh_q && !wh_q && $past(rh_q || wh_q) && !wr_en) |=> $stable(vis));

endmodule

// File: rtl/rtc_dbuf_top.sv
module rtc_dbuf_top
  import rtc_dbuf_pkg::*;
#(
  parameter int unsigned MIN_LOW_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       vcc_in_tol,
  input  logic       vcc_below_bat,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic [2:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_en
);

  logic      wr_en, rd_en, rhalt, whalt, load;
  rtc_time_t cur, vis, load_val;
  logic [7:0] rd_byte;

  rtc_dbuf_bus u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .vcc_in_tol(vcc_in_tol), .vcc_below_bat(vcc_below_bat),
    .wr_en(wr_en), .rd_en(rd_en)
  );

  rtc_dbuf_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .load(load),
    .load_val(load_val), .cur(cur)
  );

  rtc_dbuf_shadow #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_shadow (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .wr_en(wr_en), .addr(addr),
    .wdata(din), .cur(cur), .vis(vis), .rhalt(rhalt), .whalt(whalt),
    .load(load), .load_val(load_val)
  );

  always_comb begin
    rd_byte = field_at(vis, addr);
    if (addr == A_CTRL) rd_byte = {whalt, rhalt, vis.cen[5:0]};
  end

  assign dout    = rd_en ? rd_byte : 8'h00;
  assign dout_en = rd_en;

  assert_ctrl_reflects_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CTRL) |-> dout[7:6] == {whalt, rhalt});

endmodule

// File: tb/rtc_dbuf_top_bench.sv
module rtc_dbuf_top_bench;

  localparam int MIN_LOW = 8;
  localparam int NVEC = 9;

  // bytes high to low: cen yr mon date day hr min sec
  localparam logic [63:0] VEC_START [NVEC] = '{
    64'h20_24_06_15_03_12_34_56, 64'h20_24_06_15_03_00_00_59,
    64'h20_24_06_15_03_00_59_59, 64'h20_24_06_10_07_23_59_59,
    64'h20_23_02_28_02_23_59_59, 64'h20_24_02_28_02_23_59_59,
    64'h20_24_04_30_05_23_59_59, 64'h20_99_12_31_04_23_59_59,
    64'h20_24_01_30_01_23_59_59
  };
  localparam logic [63:0] VEC_EXP [NVEC] = '{
    64'h20_24_06_15_03_12_34_57, 64'h20_24_06_15_03_00_01_00,
    64'h20_24_06_15_03_01_00_00, 64'h20_24_06_11_01_00_00_00,
    64'h20_23_03_01_03_00_00_00, 64'h20_24_02_29_03_00_00_00,
    64'h20_24_05_01_06_00_00_00, 64'h21_00_01_01_05_00_00_00,
    64'h20_24_01_31_02_00_00_00
  };

  logic clk = 0, rst_n = 0, tick = 0, vin = 1, vbat = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [2:0] addr = 0;
  logic [7:0] din = 0, dout;
  logic dout_en;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_dbuf_top #(.MIN_LOW_CYC(MIN_LOW)) u_rtc_dbuf_top (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .vcc_in_tol(vin),
    .vcc_below_bat(vbat), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [7:0] byte_at(input logic [63:0] t, input int a);
    if (a == 0) return t[63:56];
    if (a == 7) return t[55:48];
    return t[(a-1)*8 +: 8];
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
    @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d, output logic en);
    @(negedge clk);
    ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    #1; d = dout; en = dout_en;
    @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic load_time(input logic [63:0] t);
    bus_write(3'd0, {2'b10, t[61:56]});
    for (int a = 1; a < 8; a++) bus_write(3'(a), byte_at(t, a));
    bus_write(3'd0, {2'b00, t[61:56]});
    wait_cyc(MIN_LOW + 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic en;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);

    // reset state
    check("reset idle dout_en R9", 32'(dout_en), 0);
    bus_read(3'd1, d, en); check("reset sec R2", 32'(d), 32'h00);
    check("read drives R9", 32'(en), 1);
    bus_read(3'd5, d, en); check("reset date R3", 32'(d), 32'h01);
    bus_read(3'd0, d, en); check("reset ctrl R4", 32'(d), 32'h20);

    // vector table: load, one tick, read all registers
    for (int i = 0; i < NVEC; i++) begin
      load_time(VEC_START[i]);
      pulse_tick();
      wait_cyc(3);
      for (int a = 0; a < 8; a++) begin
        bus_read(3'(a), d, en);
        check($sformatf("R2 R3 R7 vec%0d addr%0d", i, a), 32'(d), 32'(byte_at(VEC_EXP[i], a)));
      end
    end

    // R9 decode corners
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1; #1;
    check("R9 ce low oe we high", 32'(dout_en), 0);
    ce_n = 1; oe_n = 0; #1;
    check("R9 ce high", 32'(dout_en), 0);
    @(negedge clk); oe_n = 1;

    // read halt: freeze while counters run
    load_time(64'h20_24_06_15_03_10_00_00);
    bus_write(3'd0, 8'h60);
    for (int t = 0; t < 3; t++) begin pulse_tick(); wait_cyc(1); end
    bus_read(3'd0, d, en); check("R4 ctrl shows read halt", 32'(d), 32'h60);
    bus_read(3'd1, d, en); check("R5 frozen sec", 32'(d), 32'h00);
    bus_write(3'd0, 8'h20);
    wait_cyc(1);
    bus_read(3'd1, d, en); check("R6 inside guard", 32'(d), 32'h00);
    wait_cyc(MIN_LOW + 2);
    bus_read(3'd1, d, en); check("R6 R1 after guard", 32'(d), 32'h03);

    // R8: plain write overwritten at next refresh
    bus_write(3'd1, 8'h45);
    bus_read(3'd1, d, en); check("R8 visible write", 32'(d), 32'h45);
    pulse_tick(); wait_cyc(3);
    bus_read(3'd1, d, en); check("R8 overwritten", 32'(d), 32'h04);

    // R9: write with chip deselected ignored
    @(negedge clk); ce_n = 1; we_n = 0; addr = 3'd1; din = 8'h33;
    @(negedge clk); we_n = 1;
    bus_read(3'd1, d, en); check("R9 deselected write", 32'(d), 32'h04);

    // R10: supply gating
    vin = 0;
    bus_write(3'd1, 8'h33);
    bus_read(3'd1, d, en); check("R10 read gated", 32'(en), 0);
    vin = 1;
    bus_read(3'd1, d, en); check("R10 write ignored", 32'(d), 32'h04);
    vbat = 1;
    bus_read(3'd1, d, en); check("R10 below backup", 32'(en), 0);
    vbat = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule